// File: doc/BRIEF.md
# Mapped Multi-Core Interrupt Router

This block routes 32 level-sensitive interrupt sources onto 16 interrupt wires that lead to 4 cores, each core having 4 interrupt lines. Every source owns a routing byte. The low nibble of that byte picks which cores the source reaches, and the high nibble picks which core interrupt lines it reaches. A global enable mask gates the sources before routing.

Software reaches the block over a small synchronous register bus with byte and word transfers. Through this bus it programs the routing bytes and the enable mask. It can also read the masked source status, both globally and as seen by each core. The per-core views are derived from the live state and hold no storage of their own. The output wires are registered, so an output changes exactly one clock after the input, enable or routing change that caused it.

Top module: `irqRouter`

## Requirements
- R1: After reset every routing byte, the enable mask, `irqOut` and `busRdata` are all zero.
- R2: A byte write (busSize=0) to an address from 0x00 to 0x1F stores busWdata[7:0] as the routing byte of the source with that index. A byte read of the same address returns the byte zero-extended. Routing bits 3:0 select cores 0 to 3, and routing bits 7:4 select lines 0 to 3.
- R3: A word write to 0x28 ORs busWdata into the enable mask. A word write to 0x2C clears each enable bit that is written as 1. A word read of 0x24 returns the enable mask.
- R4: A word read of 0x20 returns the current `irqIn` ANDed with the enable mask.
- R5: A word read of 0x40 + 8*c, for c from 0 to 3, returns the enabled pending sources whose routing bit c is set.
- R6: `irqOut[4*c+l]` is 1 exactly when core c has at least one enabled pending source routed to it, and at least one enabled pending source has routing bit 4+l set. The two sources need not be the same.
- R7: `irqOut` is registered. It reflects the inputs, enable mask and routing bytes as they stood at the previous rising clock edge, and it does not change while those stay constant.
- R8: A byte access outside 0x00 to 0x1F, a word access with address bits 1:0 nonzero, and a word access at 0x40 + 8*c + 4 are all ignored. Reads of these return 0.
- R9: Word reads of unmapped aligned offsets return 0. Word writes to any offset other than 0x28 and 0x2C change no state, and this includes 0x20, 0x24, the per-core slots and the routing range.
- R10: Read data appears on `busRdata` in the cycle after a read request (busValid=1, busWrite=0). In every other cycle `busRdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| irqIn | input | 32 | Level-sensitive interrupt sources |
| busValid | input | 1 | Bus request in this cycle |
| busWrite | input | 1 | 1 for write, 0 for read |
| busSize | input | 1 | 0 for byte transfer, 1 for word transfer |
| busAddr | input | 7 | Byte address |
| busWdata | input | 32 | Write data (byte transfers use bits 7:0) |
| busRdata | output | 32 | Read data, valid the cycle after a read request |
| irqOut | output | 16 | Routed interrupt wires, index 4*core+line |

## Verification
A corrupted routing byte or enable bit shows on `irqOut` on the first clock after a source that depends on it becomes active. It shows on `busRdata` one cycle after any read of the routing, status or enable registers. The bench runs a behavioural model alongside the design and compares both outputs on every cycle, so a wrong state is caught at that first visible cycle. Sources are deliberately split so that one supplies the core condition and another supplies the line condition. This exposes a design that wrongly requires a single source to satisfy both.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int SRC_CNT    = 32;
  localparam int CORE_CNT   = 4;
  localparam int LINE_CNT   = 4;
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 32;
  localparam int ROUTE_W    = CORE_CNT + LINE_CNT;
  localparam int OUT_CNT    = CORE_CNT * LINE_CNT;
  localparam int SRC_IDX_W  = $clog2(SRC_CNT);
  localparam int CORE_IDX_W = $clog2(CORE_CNT);
  localparam int CORE_STRIDE = 8;
  localparam int STRIDE_SH  = $clog2(CORE_STRIDE);

  // register window
  localparam logic [ADDR_W-1:0] OFS_ROUTE_END = ADDR_W'(SRC_CNT);
  localparam logic [ADDR_W-1:0] OFS_GSTAT     = 7'h20;
  localparam logic [ADDR_W-1:0] OFS_ENABLE    = 7'h24;
  localparam logic [ADDR_W-1:0] OFS_EN_SET    = 7'h28;
  localparam logic [ADDR_W-1:0] OFS_EN_CLR    = 7'h2C;
  localparam logic [ADDR_W-1:0] OFS_CORE_BASE = 7'h40;
  localparam logic [ADDR_W-1:0] CORE_SPAN     = ADDR_W'(CORE_CNT * CORE_STRIDE);

  typedef enum logic [2:0] {
    RD_NONE,
    RD_ROUTE,
    RD_GSTAT,
    RD_ENABLE,
    RD_CORE
  } rdSel_e;

  typedef struct packed {
    logic                  routeWr;
    logic [SRC_IDX_W-1:0]  routeIdx;
    logic                  enSet;
    logic                  enClr;
    rdSel_e                rdSel;
    logic [CORE_IDX_W-1:0] coreIdx;
  } ctrlStrobe_t;
endpackage

// File: rtl/irqRouterCtrl.sv
module irqRouterCtrl
  import irq_router_pkg::*;
(
  input  logic              busValid,
  input  logic              busWrite,
  input  logic              busSize,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       strobe
);
  logic [ADDR_W-1:0] coreOfs;
  logic              inCoreWin;
  logic              wordAligned;

  assign coreOfs     = busAddr - OFS_CORE_BASE;
  assign inCoreWin   = coreOfs < CORE_SPAN;
  assign wordAligned = busAddr[1:0] == 2'b00;

  always_comb begin
    strobe = '0;
    strobe.routeIdx = busAddr[SRC_IDX_W-1:0];
    strobe.coreIdx  = coreOfs[STRIDE_SH +: CORE_IDX_W];
    if (busValid) begin
      if (!busSize) begin
        // byte transfers reach only the routing bytes
        if (busAddr < OFS_ROUTE_END) begin
          if (busWrite) strobe.routeWr = 1'b1;
          else          strobe.rdSel   = RD_ROUTE;
        end
      end else if (wordAligned) begin
        if (inCoreWin) begin
          // per-core views are read-only; the odd word of a slot is a hole
          if (!busWrite && coreOfs[STRIDE_SH-1:0] == '0)
            strobe.rdSel = RD_CORE;
        end else begin
          unique case (busAddr)
            OFS_GSTAT:  if (!busWrite) strobe.rdSel = RD_GSTAT;
            OFS_ENABLE: if (!busWrite) strobe.rdSel = RD_ENABLE;
            OFS_EN_SET: if (busWrite)  strobe.enSet = 1'b1;
            OFS_EN_CLR: if (busWrite)  strobe.enClr = 1'b1;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/irqRouterDatapath.sv
module irqRouterDatapath
  import irq_router_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [SRC_CNT-1:0] irqIn,
  input  ctrlStrobe_t        strobe,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic [OUT_CNT-1:0] irqOut,
  output logic [SRC_CNT-1:0] enableQ
);
  logic [ROUTE_W-1:0] routeQ [SRC_CNT];
  logic [SRC_CNT-1:0] gStat;
  logic [CORE_CNT-1:0][SRC_CNT-1:0] coreStat;
  logic [LINE_CNT-1:0][SRC_CNT-1:0] lineStat;
  logic [OUT_CNT-1:0] outNext;
  logic [DATA_W-1:0]  rdNext;
  logic [SRC_CNT-1:0] enSetMask;
  logic [SRC_CNT-1:0] enClrMask;

  // routing byte storage, one register per source
  for (genvar s = 0; s < SRC_CNT; s++) begin : g_route
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        routeQ[s] <= '0;
      else if (strobe.routeWr && strobe.routeIdx == SRC_IDX_W'(s))
        routeQ[s] <= busWdata[ROUTE_W-1:0];
    end
  end

  assign enSetMask = strobe.enSet ? busWdata[SRC_CNT-1:0] : '0;
  assign enClrMask = strobe.enClr ? busWdata[SRC_CNT-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enableQ <= '0;
    else       enableQ <= (enableQ | enSetMask) & ~enClrMask;
  end

  assign gStat = irqIn & enableQ;

  // fan each enabled source out to its cores and lines
  for (genvar s = 0; s < SRC_CNT; s++) begin : g_fan
    for (genvar c = 0; c < CORE_CNT; c++) begin : g_core
      assign coreStat[c][s] = gStat[s] & routeQ[s][c];
    end
    for (genvar l = 0; l < LINE_CNT; l++) begin : g_line
      assign lineStat[l][s] = gStat[s] & routeQ[s][CORE_CNT + l];
    end
  end

  for (genvar c = 0; c < CORE_CNT; c++) begin : g_outC
    for (genvar l = 0; l < LINE_CNT; l++) begin : g_outL
      assign outNext[c*LINE_CNT + l] = (|coreStat[c]) & (|lineStat[l]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= '0;
    else       irqOut <= outNext;
  end

  always_comb begin
    unique case (strobe.rdSel)
      RD_ROUTE:  rdNext = DATA_W'(routeQ[strobe.routeIdx]);
      RD_GSTAT:  rdNext = DATA_W'(gStat);
      RD_ENABLE: rdNext = DATA_W'(enableQ);
      RD_CORE:   rdNext = DATA_W'(coreStat[strobe.coreIdx]);
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdata <= '0;
    else       busRdata <= rdNext;
  end
endmodule

// File: rtl/irqRouter.sv
module irqRouter
  import irq_router_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [SRC_CNT-1:0] irqIn,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic               busSize,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic [OUT_CNT-1:0] irqOut
);
  ctrlStrobe_t        strobe;
  logic [SRC_CNT-1:0] enableQ;

  irqRouterCtrl ctrlI (
    .busValid (busValid),
    .busWrite (busWrite),
    .busSize  (busSize),
    .busAddr  (busAddr),
    .strobe   (strobe)
  );

  irqRouterDatapath dpI (
    .clk      (clk),
    .rstN     (rstN),
    .irqIn    (irqIn),
    .strobe   (strobe),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .irqOut   (irqOut),
    .enableQ  (enableQ)
  );
endmodule

// File: rtl/irqRouterChecker.sv
module irqRouterChecker
  import irq_router_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [SRC_CNT-1:0] irqIn,
  input logic               busValid,
  input logic               busWrite,
  input logic               busSize,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busWdata,
  input logic [DATA_W-1:0]  busRdata,
  input logic [OUT_CNT-1:0] irqOut,
  input logic [SRC_CNT-1:0] enableQ
);
  logic wordWr;
  assign wordWr = busValid && busWrite && busSize;

  p_enable_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    wordWr && busAddr == OFS_EN_SET |=>
      (enableQ & $past(busWdata[SRC_CNT-1:0])) == $past(busWdata[SRC_CNT-1:0]));

  p_enable_clr_r3: assert property (@(posedge clk) disable iff (!rstN)
    wordWr && busAddr == OFS_EN_CLR |=>
      (enableQ & $past(busWdata[SRC_CNT-1:0])) == '0);

  p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (irqIn & enableQ) == '0 |=> irqOut == '0);

  p_out_needs_pending_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqOut != '0 |-> $past((irqIn & enableQ) != '0));

  p_out_steady_r7: assert property (@(posedge clk) disable iff (!rstN)
    $stable(irqIn) && !$past(busValid && busWrite) |=> $stable(irqOut));

  p_idle_rdata_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && !busWrite) |=> busRdata == '0);
endmodule

bind irqRouter irqRouterChecker chkI (
  .clk      (clk),
  .rstN     (rstN),
  .irqIn    (irqIn),
  .busValid (busValid),
  .busWrite (busWrite),
  .busSize  (busSize),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .irqOut   (irqOut),
  .enableQ  (enableQ)
);

// File: tb/irqRouter_tb_top.sv
module irqRouter_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqIn = '0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic        busSize = 1'b0;
  logic [6:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [15:0] irqOut;

  int total = 0;
  int bad = 0;
  string curReq = "R1";

  logic [7:0]  mRoute [32];
  logic [31:0] mEn;

  always #10 clk = ~clk;

  irqRouter dut_i (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .busValid(busValid),
    .busWrite(busWrite), .busSize(busSize), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] coreView(input int c);
    logic [31:0] v = '0;
    for (int s = 0; s < 32; s++)
      if (irqIn[s] && mEn[s] && mRoute[s][c]) v[s] = 1'b1;
    return v;
  endfunction

  function automatic logic [15:0] modelOut();
    logic [15:0] o = '0;
    for (int c = 0; c < 4; c++) begin
      for (int l = 0; l < 4; l++) begin
        bit coreHit = 0;
        bit lineHit = 0;
        for (int s = 0; s < 32; s++) begin
          if (irqIn[s] && mEn[s] && mRoute[s][c]) coreHit = 1;
          if (irqIn[s] && mEn[s] && mRoute[s][4+l]) lineHit = 1;
        end
        o[4*c+l] = coreHit && lineHit;
      end
    end
    return o;
  endfunction

  function automatic logic [31:0] modelRead();
    int a = int'(busAddr);
    if (!busValid || busWrite) return '0;
    if (!busSize) return (a < 32) ? {24'h0, mRoute[a]} : '0;
    if (a % 4 != 0) return '0;
    if (a >= 64 && a < 96) return ((a - 64) % 8 != 0) ? '0 : coreView((a - 64) / 8);
    if (a == 32) return irqIn & mEn;
    if (a == 36) return mEn;
    return '0;
  endfunction

  function automatic void modelApply();
    int a = int'(busAddr);
    if (!busValid || !busWrite) return;
    if (!busSize) begin
      if (a < 32) mRoute[a] = busWdata[7:0];
    end else if (a == 40) mEn = mEn | busWdata;
    else if (a == 44) mEn = mEn & ~busWdata;
  endfunction

  // one clock: compare outputs against the model, then advance the model
  task automatic step();
    logic [15:0] expOut;
    logic [31:0] expRd;
    @(posedge clk);
    @(negedge clk);
    expOut = modelOut();
    expRd  = modelRead();
    check(curReq, "irqOut", {16'h0, irqOut}, {16'h0, expOut});
    check(curReq, "busRdata", busRdata, expRd);
    modelApply();
  endtask

  task automatic busOp(input bit wr, input bit sz, input int addr, input logic [31:0] data);
    busValid = 1'b1;
    busWrite = wr;
    busSize  = sz;
    busAddr  = 7'(addr);
    busWdata = data;
    step();
    busValid = 1'b0;
    busWrite = 1'b0;
    busWdata = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < 32; s++) mRoute[s] = '0;
    mEn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state, checked directly
    check("R1", "irqOut after reset", {16'h0, irqOut}, 32'h0);
    check("R1", "busRdata after reset", busRdata, 32'h0);
    curReq = "R1";
    irqIn = 32'hFFFF_FFFF;
    busOp(0, 1, 36, 0);
    busOp(0, 0, 5, 0);
    busOp(0, 1, 32, 0);
    idle(1);
    irqIn = '0;

    // R2: routing bytes
    curReq = "R2";
    busOp(1, 0, 0, 32'h11);
    busOp(1, 0, 1, 32'hABCD_FF82);
    busOp(1, 0, 5, 32'h3C);
    busOp(1, 0, 9, 32'h01);
    busOp(1, 0, 10, 32'h40);
    busOp(1, 0, 31, 32'hF8);
    busOp(0, 0, 1, 0);
    check("R2", "route byte 1 direct", busRdata, 32'h82);
    busOp(0, 0, 31, 0);
    busOp(0, 0, 5, 0);

    // R3: enable set and clear
    curReq = "R3";
    busOp(1, 1, 40, 32'h0000_0623);
    busOp(1, 1, 40, 32'h8000_0000);
    busOp(1, 1, 44, 32'h0000_0020);
    busOp(0, 1, 36, 0);
    check("R3", "enable direct", busRdata, 32'h8000_0603);

    // R4: masked global status
    curReq = "R4";
    irqIn = 32'hFFFF_FFFF;
    busOp(0, 1, 32, 0);
    irqIn = 32'h0000_0201;
    busOp(0, 1, 32, 0);

    // R5: per-core views
    curReq = "R5";
    irqIn = 32'h8000_0623;
    for (int c = 0; c < 4; c++) busOp(0, 1, 64 + 8*c, 0);

    // R6: core and line supplied by different sources
    curReq = "R6";
    irqIn = 32'h0000_0600;
    idle(2);
    check("R6", "cross term direct", {16'h0, irqOut}, 32'h0000_0004);
    irqIn = 32'h0000_0400;
    idle(2);
    irqIn = 32'h8000_0003;
    idle(2);

    // R7: one-clock latency, steady when nothing changes
    curReq = "R7";
    irqIn = 32'h0000_0001;
    step();
    irqIn = 32'h0;
    step();
    irqIn = 32'h0000_0001;
    idle(3);
    busOp(1, 1, 44, 32'h1);
    idle(2);
    busOp(1, 1, 40, 32'h1);
    busOp(1, 0, 0, 32'h12);
    idle(2);

    // R8: wrong size or alignment
    curReq = "R8";
    busOp(0, 0, 36, 0);
    busOp(0, 1, 33, 0);
    busOp(0, 1, 68, 0);
    busOp(1, 0, 40, 32'hFF);
    busOp(1, 1, 42, 32'hFFFF_FFFF);
    busOp(1, 1, 2, 32'hFFFF_FFFF);
    busOp(0, 1, 36, 0);
    check("R8", "enable untouched", busRdata, 32'h8000_0603);

    // R9: unmapped and read-only offsets
    curReq = "R9";
    busOp(1, 1, 32, 32'hFFFF_FFFF);
    busOp(1, 1, 36, 32'hFFFF_FFFF);
    busOp(1, 1, 64, 32'hFFFF_FFFF);
    busOp(1, 1, 0, 32'hFFFF_FFFF);
    busOp(1, 1, 48, 32'hFFFF_FFFF);
    busOp(0, 1, 48, 0);
    busOp(0, 1, 60, 0);
    busOp(0, 1, 0, 0);
    busOp(0, 1, 64, 0);
    busOp(0, 0, 0, 0);
    check("R9", "route byte 0 kept", busRdata, 32'h12);

    // R10: read data timing
    curReq = "R10";
    busOp(0, 1, 36, 0);
    idle(2);

    // mixed traffic, compared every cycle
    curReq = "R6";
    for (int i = 0; i < 600; i++) begin
      int kind = $urandom_range(0, 5);
      irqIn = $urandom();
      case (kind)
        0: busOp(1, 0, $urandom_range(0, 39), $urandom());
        1: busOp(0, 0, $urandom_range(0, 39), 0);
        2: busOp(1, 1, ($urandom_range(0, 1) != 0) ? 40 : 44, $urandom());
        3: busOp(0, 1, 4 * $urandom_range(0, 31), 0);
        4: busOp($urandom_range(0, 1) != 0, 1, $urandom_range(0, 127), $urandom());
        default: step();
      endcase
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule